// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of month, month, a two-digit year (2000 to 2099) and a weekday. A single-cycle enable input, pulsed at 32.768 kHz, drives a binary prescaler. The prescaler produces one count per second, and that count ripples through the time fields with month-length and leap-year rollover.

A host reaches the block through a byte-wide port with an address, write data, a write strobe, a read strobe and registered read data. A control byte governs operation. One bit halts counting so that a new time can be loaded. Another bit asks for a snapshot of the counters into a shadow bank. A third bit chooses whether reads of the time bytes return the shadow bank or the live counters, so the host can read several bytes that all belong to the same instant. Three further bytes (interrupt and a compensation pair) are plain storage.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0x06, and the control byte reads 0x00. Reads of any address outside 0x00-0x06, 0x10 and 0x12-0x14 return 0x00.
- R2: The address map is seconds 0x00, minutes 0x01, hours 0x02, day 0x03, month 0x04, year 0x05, weekday 0x06 and control 0x10. Read data appears on `rdata` the clock after `rd_en` is sampled high.
- R3: While running, the seconds advance exactly once per 2^DIV_W cycles with `tick32k` high. Nothing changes on cycles without a tick.
- R4: Seconds and minutes roll from 0x59 to 0x00, and hours from 0x23 to 0x00. An hour rollover advances the day and the weekday, and the weekday goes from 0x07 (Sunday) to 0x01.
- R5: The day returns to 0x01 after the last day of the month. That last day is 0x30 for months 0x04, 0x06, 0x09 and 0x11, and 0x31 for the other months except February. February ends at 0x29 when the year is divisible by 4 and at 0x28 otherwise. Day 0x31 of month 0x11 is never reached by counting.
- R6: Month rolls from 0x12 to 0x01 and advances the year. The year rolls from 0x99 to 0x00.
- R7: Control bit 0 stops counting. Writes to 0x00-0x06 take effect only while it is set and are ignored while running. After it is cleared, the first second lasts a full 2^DIV_W ticks.
- R8: While control bit 6 is set, the shadow bank copies the live counters on each `tick32k` cycle. Once the bit is clear, the shadow bank holds its contents.
- R9: With control bit 7 set, reads of 0x00-0x06 return the shadow bank. With it clear, they return the live counters.
- R10: Bytes written to 0x10, 0x12, 0x13 and 0x14 read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick32k | input | 1 | One-cycle enable at 32.768 kHz |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |

## Verification
A read result is due one clock after its strobe. The driver pushes each expected byte into a queue when it raises `rd_en`, and the monitor pops it at the falling edge after the next rising edge. A second is due on the 2^DIV_W-th tick after reset or after the stop bit is released, so the bench counts ticks exactly and reads just before and just after that boundary. A snapshot is due on the first tick after bit 6 is written, so the bench gives exactly one tick before it freezes the shadow bank and lets the live time move on.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick32k,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [7:0] rdata
);
  localparam int NT = 7;
  localparam logic [DIV_W-1:0] DIV_LAST = '1;

  function automatic logic [7:0] inc_bcd(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] mo, input logic [7:0] yr);
    logic [6:0] yb;
    yb = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mo)
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      default:                    return 8'h31;
    endcase
  endfunction

  logic [7:0] tm [NT];
  logic [7:0] sh [NT];
  logic [7:0] ctrl_r, irq_r, cmp_lo, cmp_hi, rd_val;
  logic [DIV_W-1:0] div_q;

  wire stop     = ctrl_r[0];
  wire sec_tick = tick32k && !stop && (div_q == DIV_LAST);
  wire c_min    = sec_tick && (tm[0] >= 8'h59);
  wire c_hr     = c_min && (tm[1] >= 8'h59);
  wire c_day    = c_hr && (tm[2] >= 8'h23);
  wire c_mon    = c_day && (tm[3] >= month_end(tm[4], tm[5]));
  wire c_yr     = c_mon && (tm[4] >= 8'h12);
  wire is_time  = addr < 8'd7;
  wire wr_time  = wr_en && stop && is_time;

  wire [55:0] tm_flat = {tm[6], tm[5], tm[4], tm[3], tm[2], tm[1], tm[0]};
  wire [55:0] sh_flat = {sh[6], sh[5], sh[4], sh[3], sh[2], sh[1], sh[0]};

  always_comb begin
    rd_val = 8'h00;
    if (is_time) rd_val = ctrl_r[7] ? sh[addr[2:0]] : tm[addr[2:0]];
    else case (addr)
      8'h10:   rd_val = ctrl_r;
      8'h12:   rd_val = irq_r;
      8'h13:   rd_val = cmp_lo;
      8'h14:   rd_val = cmp_hi;
      default: rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tm[0] <= 8'h00; tm[1] <= 8'h00; tm[2] <= 8'h00; tm[3] <= 8'h01;
      tm[4] <= 8'h01; tm[5] <= 8'h00; tm[6] <= 8'h06;
      for (int i = 0; i < NT; i++) sh[i] <= 8'h00;
      ctrl_r <= '0; irq_r <= '0; cmp_lo <= '0; cmp_hi <= '0;
      div_q  <= '0;
      rdata  <= '0;
    end else begin
      if (stop)         div_q <= '0;
      else if (tick32k) div_q <= div_q + 1'b1;

      if (sec_tick) begin
        tm[0] <= c_min ? 8'h00 : inc_bcd(tm[0]);
        if (c_min) tm[1] <= c_hr ? 8'h00 : inc_bcd(tm[1]);
        if (c_hr)  tm[2] <= c_day ? 8'h00 : inc_bcd(tm[2]);
        if (c_day) begin
          tm[3] <= c_mon ? 8'h01 : inc_bcd(tm[3]);
          tm[6] <= (tm[6] >= 8'h07) ? 8'h01 : inc_bcd(tm[6]);
        end
        if (c_mon) tm[4] <= c_yr ? 8'h01 : inc_bcd(tm[4]);
        if (c_yr)  tm[5] <= (tm[5] >= 8'h99) ? 8'h00 : inc_bcd(tm[5]);
      end

      if (wr_time) tm[addr[2:0]] <= wdata;
      if (wr_en) begin
        case (addr)
          8'h10: ctrl_r <= wdata;
          8'h12: irq_r  <= wdata;
          8'h13: cmp_lo <= wdata;
          8'h14: cmp_hi <= wdata;
          default: ;
        endcase
      end

      if (ctrl_r[6] && tick32k)
        for (int i = 0; i < NT; i++) sh[i] <= tm[i];

      if (rd_en) rdata <= rd_val;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick32k && !wr_en) |=> $stable(tm_flat)); // R3
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !wr_time) |=> $stable(tm_flat)); // R7
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && tm[0] == 8'h59) |=> (tm[0] == 8'h00)); // R4
  AST_NOV_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (c_day && tm[4] == 8'h11 && tm[3] == 8'h30) |=> (tm[3] == 8'h01 && tm[4] == 8'h12)); // R5
  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (c_yr && tm[5] == 8'h99) |=> (tm[5] == 8'h00)); // R6
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_r[6]) |=> $stable(sh_flat)); // R8
endmodule

// File: tb/test_bcd_rtc.sv
`timescale 1ns/1ps
module test_bcd_rtc;
  localparam int DW = 4;
  localparam int TPS = 1 << DW;

  logic clk = 0, rst_n = 0, tick32k = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic rd_q = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  bcd_rtc #(.DIV_W(DW)) i_bcd_rtc (
    .clk(clk), .rst_n(rst_n), .tick32k(tick32k), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata));

  always @(posedge clk) rd_q <= rd_en;

  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: got %02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk); rd_en = 1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick32k = 1;
      @(negedge clk); tick32k = 0;
    end
  endtask

  task automatic set_time(input logic [7:0] s, m, h, d, mo, y, w);
    wr(8'h10, 8'h01);
    wr(8'h00, s); wr(8'h01, m); wr(8'h02, h); wr(8'h03, d);
    wr(8'h04, mo); wr(8'h05, y); wr(8'h06, w);
    wr(8'h10, 8'h00);
  endtask

  task automatic chk_time(input logic [7:0] s, m, h, d, mo, y, w, input string t);
    rd(8'h00, s, t); rd(8'h01, m, t); rd(8'h02, h, t); rd(8'h03, d, t);
    rd(8'h04, mo, t); rd(8'h05, y, t); rd(8'h06, w, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state and unmapped address
    chk_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h06, "R1 reset time");
    rd(8'h10, 8'h00, "R1 reset ctrl");
    rd(8'h20, 8'h00, "R1 unmapped");
    rd(8'h11, 8'h00, "R1 unmapped 0x11");
    // R10 plain storage
    wr(8'h12, 8'hA5); wr(8'h13, 8'h3C); wr(8'h14, 8'h81);
    rd(8'h12, 8'hA5, "R10 int byte");
    rd(8'h13, 8'h3C, "R10 comp low");
    rd(8'h14, 8'h81, "R10 comp high");
    // R3 second boundary from reset (R2 map of seconds)
    ticks(TPS - 1);
    rd(8'h00, 8'h00, "R3 before boundary");
    ticks(1);
    rd(8'h00, 8'h01, "R3 after boundary");
    repeat (40) @(negedge clk);
    rd(8'h00, 8'h01, "R3 no tick no change");
    // R7 write ignored while running
    wr(8'h00, 8'h45);
    rd(8'h00, 8'h01, "R7 write while running");
    // R7 load while stopped, freeze
    wr(8'h10, 8'h01);
    wr(8'h00, 8'h12);
    ticks(3 * TPS);
    rd(8'h00, 8'h12, "R7 stopped load and freeze");
    rd(8'h10, 8'h01, "R10 ctrl readback");
    wr(8'h10, 8'h00);
    ticks(TPS - 1);
    rd(8'h00, 8'h12, "R7 full second pending");
    ticks(1);
    rd(8'h00, 8'h13, "R7 full second done");
    // R5 November ends on 30, R4 day/weekday carry
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h11, 8'h23, 8'h04);
    ticks(TPS);
    chk_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h12, 8'h23, 8'h05, "R5 Nov30 rollover");
    // R5 February non-leap and leap
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h02);
    ticks(TPS);
    chk_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h23, 8'h03, "R5 Feb28 nonleap");
    set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h03);
    ticks(TPS);
    chk_time(8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h24, 8'h04, "R5 Feb28 leap");
    set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24, 8'h04);
    ticks(TPS);
    chk_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h24, 8'h05, "R5 Feb29 leap");
    set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h24, 8'h02);
    ticks(TPS);
    chk_time(8'h00, 8'h00, 8'h00, 8'h31, 8'h01, 8'h24, 8'h03, "R5 Jan30 to 31");
    // R4 minute carry without hour carry
    set_time(8'h59, 8'h29, 8'h09, 8'h15, 8'h06, 8'h24, 8'h01);
    ticks(TPS);
    chk_time(8'h00, 8'h30, 8'h09, 8'h15, 8'h06, 8'h24, 8'h01, "R4 minute carry");
    // R6 year wrap, R4 weekday 7 to 1
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h07);
    ticks(TPS);
    chk_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01, "R6 century wrap");
    // R8 snapshot, R9 read select
    set_time(8'h30, 8'h20, 8'h10, 8'h05, 8'h07, 8'h25, 8'h06);
    wr(8'h10, 8'hC0);
    ticks(1);
    wr(8'h10, 8'h80);
    ticks(TPS - 1);
    rd(8'h00, 8'h30, "R8 shadow frozen");
    rd(8'h01, 8'h20, "R9 shadow minutes");
    wr(8'h10, 8'h00);
    rd(8'h00, 8'h31, "R9 live seconds");
    ticks(TPS);
    wr(8'h10, 8'h80);
    rd(8'h00, 8'h30, "R8 shadow still held");
    repeat (4) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule